// File: doc/BRIEF.md
# Message Buffer Command Sequence Executor

The executor turns a command program held in an input buffer RAM into accesses on a 32-bit memory-mapped target bus. Software fills the input buffer with one or more framed blocks, then writes the control register with the start bit set. The executor walks the blocks from word 0. Each block is a header word, a number of argument words and a closing block tag. It issues the single, sequential or scattered reads and writes that each block names. Every read result goes into a result buffer RAM. When the whole group has run, or the first error stops it, the executor writes a status word and a count of returned data words to the result buffer. It then raises the ready bit.

A header carries the operation code in bits 5:0, the count of words between the header and its block tag in bits 15:6, a descending block index in bits 23:16, a payload format in bits 25:24 and a revision nibble in bits 31:28. Blocks chain until the one whose index is zero. The word after that block's tag must be the group terminator. The executor passes payload words through unchanged. Unpacking of narrow packed samples belongs to a separate stage. While direct mode is set in the control register, the executor stays idle so that another agent can drive the target bus.

Top module: `msgbuf_exec`

## Requirements
- R1: After reset, ctrl_rdata reads 0x01 (ready set, busy/start, read-select and direct bits clear) and bus_req is low.
- R2: A control write with bit 7 set and bit 5 clear, while idle, starts a run at input word 0. During the run bit 0 (ready) reads 0 and bit 7 (busy) reads 1. Ready returns to 1 only after status and count have been written.
- R3: A header with bit 31 clear ends the run with status 0x8020. Revision nibbles 0xA and 0xB are accepted. Any other nibble with bit 31 set ends the run with status 0x8000.
- R4: Operation 0x02 (single write: address, data) writes one word. Operation 0x01 (single read: address) reads one word.
- R5: Operations 0x04 (address, count, then count data words) and 0x03 (address, count) access count consecutive addresses, starting at the given address and counting upward.
- R6: Operation 0x06 takes address/data pairs and performs nwords/2 writes. Operation 0x05 takes a list of addresses and performs nwords reads, in list order.
- R7: The result buffer holds the status at word 0, the number of returned data words at word 1, and the read data in issue order from word 2. On success the status is 0. Any non-zero status has bit 15 set.
- R8: The word at header position + 1 + nwords must have 0xAA55 in bits 31:16. Any value in bits 15:0 is accepted. A mismatch ends the run with status 0x8001.
- R9: After the tag of a block whose index is non-zero, the next word is taken as a header. After the tag of index 0, a word whose bits 31:16 are 0xDD33 ends the run with status 0. Any other word ends it with status 0x8002.
- R10: A bus request that sees no bus_ack within TIMEOUT (256) cycles is dropped after exactly 256 request cycles. The run ends with status 0x8004.
- R11: If bus_grant is low when an access is due, no request is raised and the run ends with status 0x8008.
- R12: An operation code outside 0x01..0x06 (flash codes included) ends the run with status 0x8000, with no bus access.
- R13: While control bit 5 (direct) is set, a start is ignored: ready stays 1, no bus request is made and the result buffer is not written. direct_mode follows bit 5 and mrb_host_sel follows bit 6.
- R14: The format field (bits 25:24) does not change the data: payload words reach bus_wdata unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (7 start, 6 read select, 5 direct) |
| ctrl_rdata | output | 8 | Control read data (7 busy, 6 read select, 5 direct, 0 ready) |
| direct_mode | output | 1 | Direct mode bit |
| mrb_host_sel | output | 1 | Result buffer read mux select |
| mib_addr | output | AW | Input buffer read address |
| mib_rdata | input | 32 | Input buffer read data, one cycle after address |
| mrb_we | output | 1 | Result buffer write enable |
| mrb_addr | output | AW | Result buffer write address |
| mrb_wdata | output | 32 | Result buffer write data |
| bus_grant | input | 1 | Target bus granted to executor |
| bus_req | output | 1 | Target access request, held until ack or timeout |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Target address |
| bus_wdata | output | 32 | Target write data |
| bus_rdata | input | 32 | Target read data, valid with bus_ack |
| bus_ack | input | 1 | Target acknowledge, one cycle |

## Verification
A wrong pointer or a misread word count makes the sequencer check the wrong word for the block tag. This appears at the result buffer as status 0x8001 or 0x8002 in place of 0, even though the bus traffic up to that point looked correct. A wrong access counter or address step shows up at once: the bus writes land at the wrong target addresses, or word 1 of the result buffer holds the wrong count, and the read-back words in the next block do not match. Timer and grant faults show up as a status other than the expected one, or as a request length other than 256 cycles, which is counted at the bus_req port.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

    localparam logic [15:0] BLK_TAG = 16'hAA55;
    localparam logic [15:0] END_TAG = 16'hDD33;

    localparam logic [5:0] OP_SRD = 6'h01;
    localparam logic [5:0] OP_SWR = 6'h02;
    localparam logic [5:0] OP_MRD = 6'h03;
    localparam logic [5:0] OP_MWR = 6'h04;
    localparam logic [5:0] OP_RRD = 6'h05;
    localparam logic [5:0] OP_RWR = 6'h06;

    localparam logic [15:0] ERR_GEN   = 16'h8000;
    localparam logic [15:0] ERR_NOBLK = 16'h8001;
    localparam logic [15:0] ERR_NOEND = 16'h8002;
    localparam logic [15:0] ERR_NOACK = 16'h8004;
    localparam logic [15:0] ERR_NOGNT = 16'h8008;
    localparam logic [15:0] ERR_OLD   = 16'h8020;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_HDR, S_ARG1, S_ARG2, S_ITEM,
        S_ISSUE, S_BUS, S_MARK, S_ENDCHK, S_WSTAT, S_WCNT
    } seq_st_e;

    typedef struct packed {
        logic [5:0] op;
        logic [9:0] nwords;
        logic [7:0] blk;
    } hdr_t;

endpackage

// File: rtl/msgbuf_hdr_decode.sv
module msgbuf_hdr_decode
    import msgbuf_pkg::*;
(
    input  logic [31:0] word,
    output hdr_t        fields,
    output logic        old_fmt,
    output logic        rev_ok,
    output logic        op_ok
);
    logic unused_fmt_bits;

    always_comb begin
        fields.op     = word[5:0];
        fields.nwords = word[15:6];
        fields.blk    = word[23:16];
        old_fmt       = ~word[31];
        rev_ok        = (word[31:28] == 4'hA) || (word[31:28] == 4'hB);
        op_ok         = (word[5:0] >= OP_SRD) && (word[5:0] <= OP_RWR);
    end

    assign unused_fmt_bits = ^word[27:24];

endmodule

// File: rtl/msgbuf_bus_master.sv
module msgbuf_bus_master #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iss,
    input  logic ack,
    output logic req,
    output logic done,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] tmr;
    } bm_s;

    bm_s q, d;

    always_comb begin
        d       = q;
        done    = q.busy & ack;
        expired = q.busy & ~ack & (q.tmr == TW'(TIMEOUT - 1));
        if (iss) begin
            d.busy = 1'b1;
            d.tmr  = '0;
        end else if (q.busy) begin
            if (ack || expired) d.busy = 1'b0;
            else                d.tmr  = q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req = q.busy;

    // R10: a request is held until ack or expiry
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !expired) |=> req);
    // R10: one access per request
    a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

endmodule

// File: rtl/msgbuf_seq.sv
module msgbuf_seq
    import msgbuf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    output logic [7:0]    ctrl_rdata,
    output logic          direct_mode,
    output logic          mrb_host_sel,
    output logic [AW-1:0] mib_addr,
    input  logic [31:0]   mib_rdata,
    input  hdr_t          hf,
    input  logic          old_fmt,
    input  logic          rev_ok,
    input  logic          op_ok,
    output logic          mrb_we,
    output logic [AW-1:0] mrb_addr,
    output logic [31:0]   mrb_wdata,
    input  logic          bus_grant,
    output logic          iss,
    output logic          acc_we,
    output logic [31:0]   acc_addr,
    output logic [31:0]   acc_wdata,
    input  logic          done,
    input  logic          expired,
    input  logic [31:0]   bus_rdata
);
    typedef struct packed {
        seq_st_e       st;
        seq_st_e       ret;
        logic [AW-1:0] ptr;
        logic [AW-1:0] mrk;
        logic [AW-1:0] rcnt;
        logic [5:0]    op;
        logic [9:0]    nw;
        logic [7:0]    blk;
        logic [31:0]   addr;
        logic [31:0]   wdata;
        logic [15:0]   cnt;
        logic          we;
        logic [15:0]   status;
        logic          ready;
        logic          rdsel;
        logic          direct;
    } seq_s;

    seq_s q, d;
    logic unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_wdata[4:0]};

    always_comb begin
        d         = q;
        iss       = 1'b0;
        mrb_we    = 1'b0;
        mrb_addr  = '0;
        mrb_wdata = '0;

        if (ctrl_we) begin
            d.rdsel  = ctrl_wdata[6];
            d.direct = ctrl_wdata[5];
        end

        unique case (q.st)
            S_IDLE: begin
                if (ctrl_we && ctrl_wdata[7] && !ctrl_wdata[5]) begin
                    d.ready  = 1'b0;
                    d.ptr    = '0;
                    d.rcnt   = '0;
                    d.status = '0;
                    d.st     = S_FETCH;
                    d.ret    = S_HDR;
                end
            end
            S_FETCH: d.st = q.ret;
            S_HDR: begin
                if (old_fmt) begin
                    d.status = ERR_OLD;
                    d.st     = S_WSTAT;
                end else if (!rev_ok || !op_ok) begin
                    d.status = ERR_GEN;
                    d.st     = S_WSTAT;
                end else begin
                    d.op  = hf.op;
                    d.nw  = hf.nwords;
                    d.blk = hf.blk;
                    d.mrk = q.ptr + AW'(1) + AW'(hf.nwords);
                    d.st  = S_FETCH;
                    if (hf.nwords == '0) begin
                        d.ptr = q.ptr + AW'(1);
                        d.ret = S_MARK;
                    end else begin
                        d.ptr = q.ptr + AW'(1);
                        d.ret = S_ARG1;
                    end
                end
            end
            S_ARG1: begin
                d.addr = mib_rdata;
                unique case (q.op)
                    OP_SRD: begin
                        d.cnt = 16'd1;
                        d.we  = 1'b0;
                        d.st  = S_ISSUE;
                    end
                    OP_RRD: begin
                        d.cnt = 16'(q.nw);
                        d.we  = 1'b0;
                        d.st  = S_ISSUE;
                    end
                    OP_RWR: begin
                        d.cnt = 16'(q.nw[9:1]);
                        d.st  = S_FETCH;
                        if (q.nw[9:1] == '0) begin
                            d.ptr = q.mrk;
                            d.ret = S_MARK;
                        end else begin
                            d.ptr = q.ptr + AW'(1);
                            d.ret = S_ARG2;
                        end
                    end
                    default: begin
                        d.ptr = q.ptr + AW'(1);
                        d.st  = S_FETCH;
                        d.ret = S_ARG2;
                    end
                endcase
            end
            S_ARG2: begin
                unique case (q.op)
                    OP_SWR, OP_RWR: begin
                        d.wdata = mib_rdata;
                        d.we    = 1'b1;
                        if (q.op == OP_SWR) d.cnt = 16'd1;
                        d.st    = S_ISSUE;
                    end
                    default: begin
                        d.cnt = mib_rdata[15:0];
                        d.we  = (q.op == OP_MWR);
                        if (mib_rdata[15:0] == '0) begin
                            d.ptr = q.mrk;
                            d.st  = S_FETCH;
                            d.ret = S_MARK;
                        end else if (q.op == OP_MWR) begin
                            d.ptr = q.ptr + AW'(1);
                            d.st  = S_FETCH;
                            d.ret = S_ITEM;
                        end else begin
                            d.st  = S_ISSUE;
                        end
                    end
                endcase
            end
            S_ITEM: begin
                unique case (q.op)
                    OP_MWR: begin
                        d.wdata = mib_rdata;
                        d.st    = S_ISSUE;
                    end
                    OP_RRD: begin
                        d.addr = mib_rdata;
                        d.st   = S_ISSUE;
                    end
                    default: begin
                        d.addr = mib_rdata;
                        d.ptr  = q.ptr + AW'(1);
                        d.st   = S_FETCH;
                        d.ret  = S_ARG2;
                    end
                endcase
            end
            S_ISSUE: begin
                if (!bus_grant) begin
                    d.status = ERR_NOGNT;
                    d.st     = S_WSTAT;
                end else begin
                    iss  = 1'b1;
                    d.st = S_BUS;
                end
            end
            S_BUS: begin
                if (done) begin
                    if (!q.we) begin
                        mrb_we    = 1'b1;
                        mrb_addr  = AW'(2) + q.rcnt;
                        mrb_wdata = bus_rdata;
                        d.rcnt    = q.rcnt + AW'(1);
                    end
                    if (q.cnt <= 16'd1) begin
                        d.ptr = q.mrk;
                        d.st  = S_FETCH;
                        d.ret = S_MARK;
                    end else begin
                        d.cnt = q.cnt - 16'd1;
                        unique case (q.op)
                            OP_MRD: begin
                                d.addr = q.addr + 32'd1;
                                d.st   = S_ISSUE;
                            end
                            OP_MWR: begin
                                d.addr = q.addr + 32'd1;
                                d.ptr  = q.ptr + AW'(1);
                                d.st   = S_FETCH;
                                d.ret  = S_ITEM;
                            end
                            default: begin
                                d.ptr = q.ptr + AW'(1);
                                d.st  = S_FETCH;
                                d.ret = S_ITEM;
                            end
                        endcase
                    end
                end else if (expired) begin
                    d.status = ERR_NOACK;
                    d.st     = S_WSTAT;
                end
            end
            S_MARK: begin
                if (mib_rdata[31:16] != BLK_TAG) begin
                    d.status = ERR_NOBLK;
                    d.st     = S_WSTAT;
                end else begin
                    d.ptr = q.ptr + AW'(1);
                    d.st  = S_FETCH;
                    d.ret = S_ENDCHK;
                end
            end
            S_ENDCHK: begin
                if (q.blk == '0) begin
                    d.status = (mib_rdata[31:16] == END_TAG) ? 16'h0000 : ERR_NOEND;
                    d.st     = S_WSTAT;
                end else begin
                    d.st = S_HDR;
                end
            end
            S_WSTAT: begin
                mrb_we    = 1'b1;
                mrb_addr  = '0;
                mrb_wdata = 32'(q.status);
                d.st      = S_WCNT;
            end
            S_WCNT: begin
                mrb_we    = 1'b1;
                mrb_addr  = AW'(1);
                mrb_wdata = 32'(q.rcnt);
                d.ready   = 1'b1;
                d.st      = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mib_addr     = q.ptr;
    assign acc_we       = q.we;
    assign acc_addr     = q.addr;
    assign acc_wdata    = q.wdata;
    assign direct_mode  = q.direct;
    assign mrb_host_sel = q.rdsel;
    assign ctrl_rdata   = {q.st != S_IDLE, q.rdsel, q.direct, 4'b0000, q.ready};

    // R2: ready rises only in the cycle after the count word is written
    a_r2_ready_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ready) |-> $past(mrb_we && mrb_addr == AW'(1)));
    // R7: a non-zero status always carries the summary bit
    a_r7_status_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (mrb_we && mrb_addr == '0 && mrb_wdata != '0) |-> mrb_wdata[15]);
    // R13: idle with direct set stays idle unless direct is being cleared
    a_r13_direct_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.direct && q.ready && !(ctrl_we && !ctrl_wdata[5])) |=> q.ready);
    // R2: nothing is written to the result buffer while ready
    a_r2_no_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        q.ready |-> !mrb_we);

endmodule

// File: rtl/msgbuf_exec.sv
module msgbuf_exec
    import msgbuf_pkg::*;
#(
    parameter int AW      = 8,
    parameter int TIMEOUT = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    output logic [7:0]    ctrl_rdata,
    output logic          direct_mode,
    output logic          mrb_host_sel,
    output logic [AW-1:0] mib_addr,
    input  logic [31:0]   mib_rdata,
    output logic          mrb_we,
    output logic [AW-1:0] mrb_addr,
    output logic [31:0]   mrb_wdata,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic          bus_we,
    output logic [31:0]   bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic [31:0]   bus_rdata,
    input  logic          bus_ack
);
    hdr_t hf;
    logic old_fmt, rev_ok, op_ok;
    logic iss, done, expired;

    msgbuf_hdr_decode u_dec (
        .word    (mib_rdata),
        .fields  (hf),
        .old_fmt (old_fmt),
        .rev_ok  (rev_ok),
        .op_ok   (op_ok)
    );

    msgbuf_seq #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .direct_mode  (direct_mode),
        .mrb_host_sel (mrb_host_sel),
        .mib_addr     (mib_addr),
        .mib_rdata    (mib_rdata),
        .hf           (hf),
        .old_fmt      (old_fmt),
        .rev_ok       (rev_ok),
        .op_ok        (op_ok),
        .mrb_we       (mrb_we),
        .mrb_addr     (mrb_addr),
        .mrb_wdata    (mrb_wdata),
        .bus_grant    (bus_grant),
        .iss          (iss),
        .acc_we       (bus_we),
        .acc_addr     (bus_addr),
        .acc_wdata    (bus_wdata),
        .done         (done),
        .expired      (expired),
        .bus_rdata    (bus_rdata)
    );

    msgbuf_bus_master #(.TIMEOUT(TIMEOUT)) u_bm (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss     (iss),
        .ack     (bus_ack),
        .req     (bus_req),
        .done    (done),
        .expired (expired)
    );

    // R4: address and data stay put while a request waits
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata)));
    // R13: no bus activity while idle in direct mode
    a_r13_no_req_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && ctrl_rdata[0]) |-> !bus_req);

endmodule

// File: tb/msgbuf_exec_tb.sv
module msgbuf_exec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic direct_mode, mrb_host_sel;
    logic [AW-1:0] mib_addr;
    logic [31:0] mib_rdata;
    logic mrb_we;
    logic [AW-1:0] mrb_addr;
    logic [31:0] mrb_wdata;
    logic bus_grant = 1'b1;
    logic bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic bus_ack = 1'b0;

    logic [31:0] mib_mem [0:255];
    logic [31:0] mrb_mem [0:255];
    logic [31:0] tgt_mem [0:255];
    int tgt_lat = 0;
    bit tgt_en = 1'b1;
    int lat_cnt = 0;
    int req_cycles = 0;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgbuf_exec #(.AW(AW), .TIMEOUT(256)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .direct_mode(direct_mode), .mrb_host_sel(mrb_host_sel),
        .mib_addr(mib_addr), .mib_rdata(mib_rdata), .mrb_we(mrb_we), .mrb_addr(mrb_addr),
        .mrb_wdata(mrb_wdata), .bus_grant(bus_grant), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    always @(posedge clk) mib_rdata <= mib_mem[mib_addr];
    always @(posedge clk) if (mrb_we) mrb_mem[mrb_addr] <= mrb_wdata;

    always @(negedge clk) begin
        if (bus_req) req_cycles = req_cycles + 1;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req && tgt_en) begin
            if (lat_cnt >= tgt_lat) begin
                bus_ack = 1'b1;
                lat_cnt = 0;
                if (bus_we) tgt_mem[bus_addr[7:0]] = bus_wdata;
                else        bus_rdata = tgt_mem[bus_addr[7:0]];
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    function automatic logic [31:0] hdr(input logic [3:0] rev, input logic [1:0] fmt,
                                        input logic [7:0] blk, input logic [9:0] nw,
                                        input logic [5:0] op);
        return {rev, 2'b00, fmt, blk, nw, op};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_bufs();
        for (int i = 0; i < 256; i++) begin
            mib_mem[i] = 32'h0;
            mrb_mem[i] = 32'hFFFF_FFFF;
        end
    endtask

    task automatic ctrl_write(input logic [7:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic run();
        int n;
        req_cycles = 0;
        ctrl_write(8'h80);
        n = 0;
        while (!ctrl_rdata[0] && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) begin
            checks++;
            fails++;
            $display("FAIL R2: run did not finish, actual busy expected ready");
        end
    endtask

    task automatic t_reset();
        check("R1 ctrl", {24'h0, ctrl_rdata}, 32'h01);
        check("R1 req", {31'h0, bus_req}, 32'h0);
    endtask

    task automatic t_single();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd1, 10'd2, 6'h02);
        mib_mem[1] = 32'h10;
        mib_mem[2] = 32'hCAFE_0001;
        mib_mem[3] = 32'hAA55_1234;
        mib_mem[4] = hdr(4'hA, 2'd0, 8'd0, 10'd1, 6'h01);
        mib_mem[5] = 32'h10;
        mib_mem[6] = 32'hAA55_0000;
        mib_mem[7] = 32'hDD33_0000;
        req_cycles = 0;
        ctrl_write(8'h80);
        check("R2 busy", {24'h0, ctrl_rdata & 8'h81}, 32'h80);
        while (!ctrl_rdata[0]) @(negedge clk);
        check("R4 target", tgt_mem[8'h10], 32'hCAFE_0001);
        check("R7 status", mrb_mem[0], 32'h0);
        check("R7 count", mrb_mem[1], 32'h1);
        check("R4 read", mrb_mem[2], 32'hCAFE_0001);
    endtask

    task automatic t_multi();
        clear_bufs();
        tgt_lat = 2;
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd1, 10'd6, 6'h04);
        mib_mem[1] = 32'h20;
        mib_mem[2] = 32'h4;
        for (int i = 0; i < 4; i++) mib_mem[3+i] = 32'h1111_0000 + i;
        mib_mem[7] = 32'hAA55_0000;
        mib_mem[8] = hdr(4'hB, 2'd0, 8'd0, 10'd2, 6'h03);
        mib_mem[9] = 32'h20;
        mib_mem[10] = 32'h4;
        mib_mem[11] = 32'hAA55_0000;
        mib_mem[12] = 32'hDD33_0000;
        run();
        tgt_lat = 0;
        check("R5 status", mrb_mem[0], 32'h0);
        check("R5 count", mrb_mem[1], 32'h4);
        for (int i = 0; i < 4; i++) begin
            check("R5 target", tgt_mem[8'h20 + i], 32'h1111_0000 + i);
            check("R5 read", mrb_mem[2+i], 32'h1111_0000 + i);
        end
        check("R3 rev B ok", mrb_mem[0], 32'h0);
    endtask

    task automatic t_random();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd1, 10'd4, 6'h06);
        mib_mem[1] = 32'h31; mib_mem[2] = 32'hAAAA_0031;
        mib_mem[3] = 32'h37; mib_mem[4] = 32'hBBBB_0037;
        mib_mem[5] = 32'hAA55_0000;
        mib_mem[6] = hdr(4'hA, 2'd0, 8'd0, 10'd3, 6'h05);
        mib_mem[7] = 32'h37; mib_mem[8] = 32'h31; mib_mem[9] = 32'h37;
        mib_mem[10] = 32'hAA55_0000;
        mib_mem[11] = 32'hDD33_0000;
        run();
        check("R6 status", mrb_mem[0], 32'h0);
        check("R6 count", mrb_mem[1], 32'h3);
        check("R6 d0", mrb_mem[2], 32'hBBBB_0037);
        check("R6 d1", mrb_mem[3], 32'hAAAA_0031);
        check("R6 d2", mrb_mem[4], 32'hBBBB_0037);
    endtask

    task automatic t_no_marker();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd0, 10'd1, 6'h01);
        mib_mem[1] = 32'h10;
        mib_mem[2] = 32'h1234_5678;
        mib_mem[3] = 32'hDD33_0000;
        run();
        check("R8 status", mrb_mem[0], 32'h8001);
        check("R8 count", mrb_mem[1], 32'h1);
    endtask

    task automatic t_no_end();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd0, 10'd1, 6'h01);
        mib_mem[1] = 32'h10;
        mib_mem[2] = 32'hAA55_0000;
        mib_mem[3] = hdr(4'hA, 2'd0, 8'd0, 10'd1, 6'h01);
        run();
        check("R9 status", mrb_mem[0], 32'h8002);
    endtask

    task automatic t_timeout();
        clear_bufs();
        tgt_en = 1'b0;
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd0, 10'd1, 6'h01);
        mib_mem[1] = 32'h10;
        mib_mem[2] = 32'hAA55_0000;
        mib_mem[3] = 32'hDD33_0000;
        run();
        tgt_en = 1'b1;
        check("R10 status", mrb_mem[0], 32'h8004);
        check("R10 req cycles", req_cycles, 32'd256);
    endtask

    task automatic t_no_grant();
        clear_bufs();
        bus_grant = 1'b0;
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd0, 10'd2, 6'h02);
        mib_mem[1] = 32'h50;
        mib_mem[2] = 32'h5;
        mib_mem[3] = 32'hAA55_0000;
        mib_mem[4] = 32'hDD33_0000;
        run();
        bus_grant = 1'b1;
        check("R11 status", mrb_mem[0], 32'h8008);
        check("R11 no req", req_cycles, 32'd0);
    endtask

    task automatic t_versions();
        clear_bufs();
        mib_mem[0] = 32'h0000_0041;
        run();
        check("R3 old", mrb_mem[0], 32'h8020);
        check("R3 old count", mrb_mem[1], 32'h0);
        clear_bufs();
        mib_mem[0] = hdr(4'hF, 2'd0, 8'd0, 10'd1, 6'h01);
        run();
        check("R3 rev F", mrb_mem[0], 32'h8000);
    endtask

    task automatic t_unknown();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd0, 10'd0, 6'h21);
        mib_mem[1] = 32'hAA55_0000;
        mib_mem[2] = 32'hDD33_0000;
        run();
        check("R12 status", mrb_mem[0], 32'h8000);
        check("R12 no req", req_cycles, 32'd0);
    endtask

    task automatic t_direct();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd0, 8'd0, 10'd1, 6'h01);
        mib_mem[1] = 32'h10;
        mib_mem[2] = 32'hAA55_0000;
        mib_mem[3] = 32'hDD33_0000;
        mrb_mem[0] = 32'h5A5A_5A5A;
        req_cycles = 0;
        ctrl_write(8'hA0);
        repeat (20) @(negedge clk);
        check("R13 ctrl", {24'h0, ctrl_rdata}, 32'h21);
        check("R13 direct pin", {31'h0, direct_mode}, 32'h1);
        check("R13 no req", req_cycles, 32'd0);
        check("R13 mrb untouched", mrb_mem[0], 32'h5A5A_5A5A);
        ctrl_write(8'h40);
        check("R13 host sel", {30'h0, mrb_host_sel, direct_mode}, 32'h2);
        ctrl_write(8'h00);
    endtask

    task automatic t_format();
        clear_bufs();
        mib_mem[0] = hdr(4'hA, 2'd2, 8'd1, 10'd3, 6'h04);
        mib_mem[1] = 32'h40;
        mib_mem[2] = 32'h1;
        mib_mem[3] = 32'h2A99_5566;
        mib_mem[4] = 32'hAA55_0000;
        mib_mem[5] = hdr(4'hA, 2'd3, 8'd0, 10'd1, 6'h01);
        mib_mem[6] = 32'h40;
        mib_mem[7] = 32'hAA55_0000;
        mib_mem[8] = 32'hDD33_0000;
        run();
        check("R14 target raw", tgt_mem[8'h40], 32'h2A99_5566);
        check("R14 read raw", mrb_mem[2], 32'h2A99_5566);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) tgt_mem[i] = 32'h0;
        clear_bufs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_random();
        t_no_marker();
        t_no_end();
        t_timeout();
        t_no_grant();
        t_versions();
        t_unknown();
        t_direct();
        t_format();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule